// File: doc/BRIEF.md
# Single-Port RAM FIFO Controller

This block turns one ordinary single-port RAM into a first-in first-out buffer. A RAM of this kind performs only one access at a time, so the controller puts every write and every read in sequence. An arbiter in the controller gives the RAM to one requester and holds the other with a wait signal until the current access has finished. The controller keeps the write and read pointers, the occupancy count and the full and empty flags. It also drives the RAM address, write enable and data lines.

Each side uses a request and wait handshake. A producer raises `wr_req` with its word on `wr_data` and holds both while `wr_wait` is high. The write is taken in the first cycle where `wr_req` is high and `wr_wait` is low. A consumer works the same way with `rd_req` and `rd_wait`, and receives the word on `rd_data` together with a one-cycle `rd_valid` strobe. Every RAM access lasts `ACC_CYC` clock cycles. When two requests are pending, the one that has waited longer is served first. When both arrive in the same cycle, a priority bit that alternates decides between them, so neither side can be starved.

Top module: `seqram_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it, `empty` is 1, `full` is 0, `count` is 0 and `rd_valid` is 0. With no request present, `wr_wait` and `rd_wait` are 0.
- R2: Words come out on `rd_data` in the order in which their writes were accepted.
- R3: In any cycle at most one side completes a handshake (request high, wait low).
- R4: When the controller is idle and only one side requests, that side's wait is high for exactly `ACC_CYC`-1 cycles. With the default of 1, the handshake completes in the same cycle as the request.
- R5: If a side waited in a cycle in which the other side completed, and it still requests in the next cycle, the other side cannot complete in that next cycle.
- R6: When both requests first appear in the same idle cycle and neither was waiting before, the alternating priority decides. The first such tie after reset goes to the write, and each later tie goes to the side that lost the previous tie.
- R7: A requester that holds its request never sees its wait high for more than 2*`ACC_CYC`-1 consecutive cycles.
- R8: A write taken while `full` is 1 raises `wr_err` in that cycle. It stores nothing and leaves `count` unchanged.
- R9: A read taken while `empty` is 1 raises `rd_err` in that cycle, produces no `rd_valid` pulse and leaves `count` unchanged.
- R10: Each accepted, non-refused write increases `count` by one and each such read decreases it by one. `full` is 1 exactly when `count` equals `DEPTH`, and `empty` is 1 exactly when `count` is 0.
- R11: The pointers wrap modulo `DEPTH`, so order is preserved over more than `DEPTH` words of traffic.
- R12: `rd_valid` is high, with the word on `rd_data`, in the cycle after a non-refused read handshake completes, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req | input | 1 | Producer requests a write |
| wr_data | input | DATA_W | Word to be written, held while `wr_wait` is high |
| wr_wait | output | 1 | Producer must hold its request |
| wr_err | output | 1 | Write refused because the buffer is full |
| rd_req | input | 1 | Consumer requests a read |
| rd_data | output | DATA_W | Word read from the RAM |
| rd_valid | output | 1 | `rd_data` carries a new word this cycle |
| rd_wait | output | 1 | Consumer must hold its request |
| rd_err | output | 1 | Read refused because the buffer is empty |
| full | output | 1 | Count equals `DEPTH` |
| empty | output | 1 | Count is zero |
| count | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
A corrupted pointer appears at the ports as a wrong word or a word out of order. The consumer sees it on the first `rd_valid` pulse that reads from the bad slot, which is at most `DEPTH` reads later. A wrong arbiter state, such as a stale waiting flag or a priority bit that does not alternate, shows up within one or two cycles of a collision: a wait lasts longer than its bound or the wrong side wins a tie. A faulty count is seen at once on `full`, `empty` or `count`, or later as an error pulse that should not occur or an overflow that goes unreported.

// File: rtl/seqram_fifo_pkg.sv
package seqram_fifo_pkg;

   typedef enum logic {
      SIDE_WR = 1'b0,
      SIDE_RD = 1'b1
   } side_e;

   function automatic int unsigned phase_width(input int unsigned acc);
      return (acc > 1) ? $clog2(acc) : 1;
   endfunction

endpackage

// File: rtl/seqram_fifo_store.sv
module seqram_fifo_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/seqram_fifo_arb.sv
module seqram_fifo_arb
   import seqram_fifo_pkg::*;
#(
   parameter int unsigned ACC_CYC = 1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_req,
   input  logic  rd_req,
   input  logic  wr_block,
   input  logic  rd_block,
   output logic  acc_on,
   output side_e acc_side,
   output logic  acc_last,
   output logic  acc_refused,
   output logic  wr_wait,
   output logic  rd_wait
);
   localparam int unsigned PH_W = phase_width(ACC_CYC);

   logic  act;
   side_e own;
   logic  done_now;
   side_e pick;
   logic  wr_old, rd_old;
   logic  favor_rd;
   logic  tie;

   // choose among fresh requests: older waiter first, else alternating priority
   always_comb begin
      if (!wr_req)                pick = SIDE_RD;
      else if (!rd_req)           pick = SIDE_WR;
      else if (wr_old && !rd_old) pick = SIDE_WR;
      else if (rd_old && !wr_old) pick = SIDE_RD;
      else                        pick = favor_rd ? SIDE_RD : SIDE_WR;
   end

   assign tie         = !act && wr_req && rd_req && (wr_old == rd_old);
   assign acc_on      = act || wr_req || rd_req;
   assign acc_side    = act ? own : pick;
   assign acc_refused = acc_on && !act &&
                        ((acc_side == SIDE_WR) ? wr_block : rd_block);
   assign acc_last    = acc_on && (acc_refused || done_now);

   assign wr_wait = wr_req && !(acc_on && acc_side == SIDE_WR && acc_last);
   assign rd_wait = rd_req && !(acc_on && acc_side == SIDE_RD && acc_last);

   generate
      if (ACC_CYC == 1) begin : g_single
         assign act      = 1'b0;
         assign own      = SIDE_WR;
         assign done_now = 1'b1;
      end else begin : g_multi
         logic [PH_W-1:0] phase;
         assign done_now = act && (phase == PH_W'(ACC_CYC - 1));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act   <= 1'b0;
               own   <= SIDE_WR;
               phase <= '0;
            end else if (!act) begin
               if (acc_on && !acc_refused) begin
                  act   <= 1'b1;
                  own   <= acc_side;
                  phase <= PH_W'(1);
               end
            end else if (done_now) begin
               act <= 1'b0;
            end else begin
               phase <= phase + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_old   <= 1'b0;
         rd_old   <= 1'b0;
         favor_rd <= 1'b0;
      end else begin
         wr_old <= wr_wait;
         rd_old <= rd_wait;
         if (tie) favor_rd <= (pick == SIDE_WR);
      end
   end
endmodule

// File: rtl/seqram_fifo_ptrs.sv
module seqram_fifo_ptrs #(
   parameter int unsigned DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_commit,
   input  logic                       rd_commit,
   output logic [$clog2(DEPTH)-1:0]   wr_addr,
   output logic [$clog2(DEPTH)-1:0]   rd_addr,
   output logic [$clog2(DEPTH):0]     count,
   output logic                       full,
   output logic                       empty
);
   localparam int unsigned AW    = $clog2(DEPTH);
   localparam int unsigned CNT_W = AW + 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_addr <= '0;
         rd_addr <= '0;
         count   <= '0;
      end else begin
         if (wr_commit) wr_addr <= wr_addr + 1'b1;
         if (rd_commit) rd_addr <= rd_addr + 1'b1;
         case ({wr_commit, rd_commit})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
endmodule

// File: rtl/seqram_fifo.sv
module seqram_fifo
   import seqram_fifo_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned ACC_CYC = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_req,
   input  logic [DATA_W-1:0]        wr_data,
   output logic                     wr_wait,
   output logic                     wr_err,
   input  logic                     rd_req,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     rd_valid,
   output logic                     rd_wait,
   output logic                     rd_err,
   output logic                     full,
   output logic                     empty,
   output logic [$clog2(DEPTH):0]   count
);
   localparam int unsigned AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("seqram_fifo: DEPTH must be a power of two of at least 2");
      end
      if (ACC_CYC < 1) begin : g_bad_acc
         $error("seqram_fifo: ACC_CYC must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("seqram_fifo: DATA_W must be at least 1");
      end
   endgenerate

   logic          acc_on, acc_last, acc_refused;
   side_e         acc_side;
   logic          wr_fire, rd_fire;
   logic [AW-1:0] wr_addr, rd_addr;
   logic          ram_en, ram_we;
   logic [AW-1:0] ram_addr;

   seqram_fifo_arb #(.ACC_CYC(ACC_CYC)) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_req      (wr_req),
      .rd_req      (rd_req),
      .wr_block    (full),
      .rd_block    (empty),
      .acc_on      (acc_on),
      .acc_side    (acc_side),
      .acc_last    (acc_last),
      .acc_refused (acc_refused),
      .wr_wait     (wr_wait),
      .rd_wait     (rd_wait)
   );

   assign wr_fire = acc_on && acc_last && !acc_refused && (acc_side == SIDE_WR);
   assign rd_fire = acc_on && acc_last && !acc_refused && (acc_side == SIDE_RD);
   assign wr_err  = acc_on && acc_refused && (acc_side == SIDE_WR);
   assign rd_err  = acc_on && acc_refused && (acc_side == SIDE_RD);

   seqram_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_commit (wr_fire),
      .rd_commit (rd_fire),
      .wr_addr   (wr_addr),
      .rd_addr   (rd_addr),
      .count     (count),
      .full      (full),
      .empty     (empty)
   );

   assign ram_en   = wr_fire || rd_fire;
   assign ram_we   = wr_fire;
   assign ram_addr = (acc_side == SIDE_WR) ? wr_addr : rd_addr;

   seqram_fifo_store #(.DATA_W(DATA_W), .ADDR_W(AW)) u_ram (
      .clk   (clk),
      .en    (ram_en),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (wr_data),
      .rdata (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_fire;
   end
endmodule

// File: rtl/seqram_fifo_chk.sv
module seqram_fifo_chk #(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned ACC_CYC = 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_req,
   input logic                   wr_wait,
   input logic                   wr_err,
   input logic                   rd_req,
   input logic                   rd_wait,
   input logic                   rd_err,
   input logic                   rd_valid,
   input logic                   full,
   input logic                   empty,
   input logic [$clog2(DEPTH):0] count
);
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

   logic wr_hs, rd_hs;
   int unsigned wr_run, rd_run;

   assign wr_hs = wr_req && !wr_wait;
   assign rd_hs = rd_req && !rd_wait;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_run <= 0;
         rd_run <= 0;
      end else begin
         wr_run <= (wr_req && wr_wait) ? wr_run + 1 : 0;
         rd_run <= (rd_req && rd_wait) ? rd_run + 1 : 0;
      end
   end

   assert_one_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_hs && rd_hs));

   assert_waiter_next_R5a: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_wait && wr_hs) |=> (!rd_req || !wr_hs));

   assert_waiter_next_R5b: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_wait && rd_hs) |=> (!wr_req || !rd_hs));

   assert_wr_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_wait) |-> (wr_run < 2 * ACC_CYC - 1));

   assert_rd_wait_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_wait) |-> (rd_run < 2 * ACC_CYC - 1));

   assert_full_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hs && full) |-> wr_err);

   assert_full_count_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |=> $stable(count));

   assert_empty_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hs && empty) |-> rd_err);

   assert_empty_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |=> !rd_valid);

   assert_count_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hs && !wr_err) |=> (count == CNT_W'($past(count) + 1'b1)));

   assert_count_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hs && !rd_err) |=> (count == CNT_W'($past(count) - 1'b1)));

   assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hs && !rd_err) |=> rd_valid);

   assert_valid_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_hs && !rd_err) |=> !rd_valid);
endmodule

bind seqram_fifo seqram_fifo_chk #(.DEPTH(DEPTH), .ACC_CYC(ACC_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_req   (wr_req),
   .wr_wait  (wr_wait),
   .wr_err   (wr_err),
   .rd_req   (rd_req),
   .rd_wait  (rd_wait),
   .rd_err   (rd_err),
   .rd_valid (rd_valid),
   .full     (full),
   .empty    (empty),
   .count    (count)
);

// File: tb/seqram_fifo_test.sv
module seqram_fifo_test;
   localparam int CLK_P  = 10;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 16;
   localparam int CNT_W  = $clog2(DEPTH) + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_req = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_req = 1'b0;
   logic              wr_wait, wr_err, rd_wait, rd_err, rd_valid, full, empty;
   logic [DATA_W-1:0] rd_data;
   logic [CNT_W-1:0]  count;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [DATA_W-1:0] sb [$];
   logic [DATA_W-1:0] next_val = 8'h10;

   always #(CLK_P/2) clk = ~clk;

   seqram_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ACC_CYC(1)) uut (
      .clk(clk), .rst_n(rst_n),
      .wr_req(wr_req), .wr_data(wr_data), .wr_wait(wr_wait), .wr_err(wr_err),
      .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_wait(rd_wait), .rd_err(rd_err),
      .full(full), .empty(empty), .count(count)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at a falling edge
   task automatic wr_op(input bit keep, output int nwait, output bit err);
      logic [DATA_W-1:0] d;
      d = next_val;
      next_val = next_val + 8'd1;
      wr_req  = 1'b1;
      wr_data = d;
      nwait   = 0;
      forever begin
         #1;
         if (!wr_wait) break;
         nwait++;
         @(negedge clk);
      end
      err = wr_err;
      if (!err) sb.push_back(d);
      @(negedge clk);
      if (!keep) wr_req = 1'b0;
   endtask

   task automatic rd_op(input bit keep, output int nwait, output bit err);
      rd_req = 1'b1;
      nwait  = 0;
      forever begin
         #1;
         if (!rd_wait) break;
         nwait++;
         @(negedge clk);
      end
      err = rd_err;
      @(negedge clk);
      // R12 / R9: strobe one cycle after a served read, none after a refused one
      check(rd_valid == !err, "R12", int'(rd_valid), int'(!err));
      if (!keep) rd_req = 1'b0;
   endtask

   // scoreboard monitor (R2, R11)
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2", int'(rd_data), -1);
         end else begin
            logic [DATA_W-1:0] e;
            e = sb.pop_front();
            check(rd_data == e, "R2", int'(rd_data), int'(e));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         check(1'b0, "watchdog", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int nw, nr, tot;
      bit ew, er;
      repeat (3) @(negedge clk);
      // R1: values while reset is held
      check(empty == 1'b1 && full == 1'b0 && count == 0 && rd_valid == 1'b0,
            "R1", int'(count), 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check(empty == 1'b1 && full == 1'b0 && count == 0, "R1", int'(count), 0);
      check(wr_wait == 1'b0 && rd_wait == 1'b0 && rd_valid == 1'b0, "R1",
            int'({wr_wait, rd_wait, rd_valid}), 0);
      @(negedge clk);

      // R9: read on empty is refused
      rd_op(1'b0, nr, er);
      check(er == 1'b1, "R9", int'(er), 1);
      check(count == 0 && empty == 1'b1, "R9", int'(count), 0);

      // R4, R10: fill to the brim, each write served at once
      tot = 0;
      for (int i = 0; i < DEPTH; i++) begin
         wr_op(i != DEPTH - 1, nw, ew);
         tot += nw;
      end
      check(tot == 0, "R4", tot, 0);
      check(count == CNT_W'(DEPTH) && full == 1'b1 && empty == 1'b0, "R10",
            int'(count), DEPTH);

      // R8: write on full is refused and stores nothing
      wr_op(1'b0, nw, ew);
      check(ew == 1'b1 && nw == 0, "R8", int'(ew), 1);
      check(count == CNT_W'(DEPTH), "R8", int'(count), DEPTH);

      // R2: drain in order
      for (int i = 0; i < DEPTH; i++) rd_op(i != DEPTH - 1, nr, er);
      @(negedge clk);
      check(count == 0 && empty == 1'b1 && full == 1'b0, "R10", int'(count), 0);

      // R6: ties alternate, first goes to the write
      wr_op(1'b0, nw, ew);
      wr_op(1'b0, nw, ew);
      fork
         wr_op(1'b0, nw, ew);
         rd_op(1'b0, nr, er);
      join
      check(nw == 0 && nr == 1, "R6", nr, 1);
      fork
         wr_op(1'b0, nw, ew);
         rd_op(1'b0, nr, er);
      join
      check(nr == 0 && nw == 1, "R6", nw, 1);
      check(count == 2, "R10", int'(count), 2);

      // R5, R7: reader arrives while the writer streams
      tot = 0;
      fork
         begin
            for (int i = 0; i < 4; i++) begin
               wr_op(i != 3, nw, ew);
               tot += nw;
            end
         end
         begin
            @(negedge clk);
            rd_op(1'b0, nr, er);
         end
      join
      check(nr == 1, "R5", nr, 1);
      check(tot == 1, "R7", tot, 1);
      check(count == 5, "R10", int'(count), 5);

      // R11: wrap the pointers several times
      for (int i = 0; i < 3 * DEPTH; i++) begin
         wr_op(1'b0, nw, ew);
         rd_op(1'b0, nr, er);
      end
      while (count != 0) rd_op(1'b0, nr, er);
      @(negedge clk);
      check(empty == 1'b1 && count == 0, "R11", int'(count), 0);
      check(sb.size() == 0, "R2", sb.size(), 0);

      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule